// File: doc/BRIEF.md
# Quadrature Encoder Timer Counter

This block is a single-channel counter with two sources of counting. In the plain mode it adds one on every clock while it runs. In the three encoder modes it turns two phase-shifted encoder lines into an up/down position count. The encoder modes use edges of the first line only, edges of the second line only, or edges of both lines. Both lines are brought into the clock domain and edge-detected inside the block.

Software drives the block through a small word-addressed register port. The control word holds the run bit, the reload-buffering bit, the mode, the read-only direction bit, a sticky wrap flag and a self-clearing reload trigger. The other registers are the count value and the ceiling, which can be read back as the active value or as the buffered value.

The count always stays between zero and the ceiling. Counting past either end wraps the count to the other end. A new ceiling takes effect at once, or waits in a buffer until the reload trigger is written.

Top module: `qenc_timer`

## Requirements
- R1: After reset the count is 0, both the active and the buffered ceiling are all ones, and every control field reads 0 (stopped, unbuffered, plain mode, forward, no wrap).
- R2: In mode 0 (control bits 3:2 = 0) the count rises by one on each clock edge at which the run bit (control bit 0) is set. The encoder lines have no effect in this mode.
- R3: In mode 1 only changes of line A count. The count goes up when A differs from B after the change, and down when they are equal. Changes of B alone leave the count unchanged.
- R4: In mode 2 only changes of line B count. The count goes up when A equals B after the change, and down when they differ. Changes of A alone leave the count unchanged.
- R5: In mode 3 every change of either line counts, using the rule of R3 for A and the rule of R4 for B, so one full encoder cycle gives four steps. Forward means A leads B.
- R6: The direction bit (control bit 4) reads 1 after a down step and 0 after an up step, and holds its value between steps.
- R7: When both lines change in the same synchronized sample, neither the count nor the direction changes.
- R8: An up step at the ceiling wraps the count to 0, and a down step at 0 loads the ceiling. Either wrap sets the wrap flag (control bit 5), which stays set until a control write with bit 5 = 1.
- R9: A count write (address 2) is accepted only when its value does not exceed the active ceiling. Making the active ceiling smaller than the count clears the count to 0.
- R10: With the buffering bit (control bit 1) at 0, a ceiling write (address 1) changes the active ceiling on the next clock.
- R11: With the buffering bit at 1, a ceiling write changes only the buffered value (readable at address 3). A control write with bit 6 = 1 copies the buffered value into the active ceiling. Bit 6 always reads 0.
- R12: While the run bit is 0, no input activity changes the count.
- R13: A change on an encoder line moves the count at the third rising clock edge after the change, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on a clock edge |
| enc_a | input | 1 | Encoder line A, asynchronous |
| enc_b | input | 1 | Encoder line B, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 ceiling, 2 count, 3 buffered ceiling |
| reg_wdata | input | CNT_W | Register write data |
| reg_rdata | output | CNT_W | Read data for reg_addr, combinational |

## Verification
Register writes take effect at the clock edge that samples the strobe, and read data follows the address without delay. The bench therefore drives every write at a falling edge and reads one nanosecond after a later falling edge. An encoder change passes two synchronizer flops and one history flop before it reaches the count. The bench checks that the count still holds its old value after two rising edges and has its new value after the third. The table walk then waits four cycles after each input change before it checks the count and the direction. In the plain mode, a run period that starts at edge E and ends with a stop written at edge E+N gives exactly N steps, and the expected counts are computed from that rule.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

  typedef enum logic [1:0] {
    MODE_UP  = 2'd0,
    MODE_X2A = 2'd1,
    MODE_X2B = 2'd2,
    MODE_X4  = 2'd3
  } qmode_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CEIL = 2'd1;
  localparam logic [1:0] ADDR_CNT  = 2'd2;
  localparam logic [1:0] ADDR_SHD  = 2'd3;

  localparam int CTL_RUN  = 0;
  localparam int CTL_PRE  = 1;
  localparam int CTL_MODE = 2;
  localparam int CTL_DIR  = 4;
  localparam int CTL_FLAG = 5;
  localparam int CTL_UPD  = 6;
  localparam int CTL_BITS = 7;

endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic edg
);
  logic [STAGES:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign lvl = sh_q[STAGES-1];
  assign edg = sh_q[STAGES] ^ sh_q[STAGES-1];
endmodule

// File: rtl/qenc_decode.sv
module qenc_decode
  import qenc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  qmode_e mode,
  input  logic   run,
  input  logic   a_lvl,
  input  logic   b_lvl,
  input  logic   a_edg,
  input  logic   b_edg,
  output logic   step,
  output logic   up
);
  logic differ;

  always_comb begin
    differ = a_lvl ^ b_lvl;
    step   = 1'b0;
    up     = 1'b1;
    case (mode)
      MODE_UP: begin
        step = run;
        up   = 1'b1;
      end
      MODE_X2A: begin
        step = run & a_edg & ~b_edg;
        up   = differ;
      end
      MODE_X2B: begin
        step = run & b_edg & ~a_edg;
        up   = ~differ;
      end
      MODE_X4: begin
        step = run & (a_edg ^ b_edg);
        up   = a_edg ? differ : ~differ;
      end
      default: begin
        step = 1'b0;
        up   = 1'b1;
      end
    endcase
  end

  // R7
  both_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_edg && b_edg && mode != MODE_UP) |-> !step);

endmodule

// File: rtl/qenc_reload.sv
module qenc_reload #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ceil_wr,
  input  logic [W-1:0] wdata,
  input  logic         preload,
  input  logic         upd,
  output logic [W-1:0] ceil_act,
  output logic [W-1:0] ceil_shd,
  output logic         ceil_load,
  output logic [W-1:0] ceil_new
);
  logic [W-1:0] act_q, shd_q, shd_d;
  logic         shd_en;

  always_comb begin
    shd_en    = ceil_wr;
    shd_d     = ceil_wr ? wdata : shd_q;
    ceil_load = upd | (ceil_wr & ~preload);
    ceil_new  = shd_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '1;
      shd_q <= '1;
    end else begin
      if (shd_en)    shd_q <= shd_d;
      if (ceil_load) act_q <= ceil_new;
    end
  end

  assign ceil_act = act_q;
  assign ceil_shd = shd_q;

  // R10
  ceil_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ceil_wr && !preload) |=> (ceil_act == $past(wdata)));

  // R11
  ceil_buffered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ceil_wr && preload && !upd) |=> $stable(ceil_act));

endmodule

// File: rtl/qenc_core.sv
module qenc_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         up,
  input  logic         cnt_wr,
  input  logic [W-1:0] cnt_wdata,
  input  logic [W-1:0] ceil_act,
  input  logic         ceil_load,
  input  logic [W-1:0] ceil_new,
  output logic [W-1:0] cnt,
  output logic         dir,
  output logic         wrap
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         dir_q, dir_d, cnt_en;

  always_comb begin
    cnt_d = cnt_q;
    dir_d = dir_q;
    wrap  = 1'b0;
    if (cnt_wr) begin
      if (cnt_wdata <= ceil_act) cnt_d = cnt_wdata;
    end else if (step) begin
      dir_d = ~up;
      if (up) begin
        if (cnt_q >= ceil_act) begin
          cnt_d = '0;
          wrap  = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else begin
        if (cnt_q == '0) begin
          cnt_d = ceil_act;
          wrap  = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
    end
    if (ceil_load && (cnt_d > ceil_new)) cnt_d = '0;
    cnt_en = cnt_wr | step | ceil_load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

  assign cnt = cnt_q;
  assign dir = dir_q;

  // R9
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= ceil_act);

  // R8
  wrap_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && up && !cnt_wr && !ceil_load && cnt_q == ceil_act) |=> (cnt_q == '0));

  // R8
  wrap_bottom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !up && !cnt_wr && !ceil_load && cnt_q == '0) |=> (cnt_q == $past(ceil_act)));

endmodule

// File: rtl/qenc_timer.sv
module qenc_timer
  import qenc_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enc_a,
  input  logic             enc_b,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata
);
  localparam int NLINES = 2;

  logic       rst_s1_q, rst_s2_q, rst_sync_n;
  logic [NLINES-1:0] raw, lvl, edg;

  logic       run_q, run_d, pre_q, pre_d, flag_q, flag_d, ctl_en;
  qmode_e     mode_q, mode_d;
  logic       ctrl_wr, ceil_wr, cnt_wr, upd;
  logic       step, up, wrap, dir, ceil_load;
  logic [CNT_W-1:0] cnt, ceil_act, ceil_shd, ceil_new;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_sync_n = rst_s2_q;

  assign raw = {enc_b, enc_a};

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    qenc_sync #(.STAGES(STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .din   (raw[i]),
      .lvl   (lvl[i]),
      .edg   (edg[i])
    );
  end

  always_comb begin
    ctrl_wr = reg_wr && (reg_addr == ADDR_CTRL);
    ceil_wr = reg_wr && (reg_addr == ADDR_CEIL);
    cnt_wr  = reg_wr && (reg_addr == ADDR_CNT);
    upd     = ctrl_wr && reg_wdata[CTL_UPD];
    ctl_en  = ctrl_wr;
    run_d   = reg_wdata[CTL_RUN];
    pre_d   = reg_wdata[CTL_PRE];
    mode_d  = qmode_e'(reg_wdata[CTL_MODE +: 2]);
    if (wrap)                                flag_d = 1'b1;
    else if (ctrl_wr && reg_wdata[CTL_FLAG]) flag_d = 1'b0;
    else                                     flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      run_q  <= 1'b0;
      pre_q  <= 1'b0;
      mode_q <= MODE_UP;
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
      if (ctl_en) begin
        run_q  <= run_d;
        pre_q  <= pre_d;
        mode_q <= mode_d;
      end
    end
  end

  qenc_decode u_decode (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .mode  (mode_q),
    .run   (run_q),
    .a_lvl (lvl[0]),
    .b_lvl (lvl[1]),
    .a_edg (edg[0]),
    .b_edg (edg[1]),
    .step  (step),
    .up    (up)
  );

  qenc_reload #(.W(CNT_W)) u_reload (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ceil_wr   (ceil_wr),
    .wdata     (reg_wdata),
    .preload   (pre_q),
    .upd       (upd),
    .ceil_act  (ceil_act),
    .ceil_shd  (ceil_shd),
    .ceil_load (ceil_load),
    .ceil_new  (ceil_new)
  );

  qenc_core #(.W(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .step      (step),
    .up        (up),
    .cnt_wr    (cnt_wr),
    .cnt_wdata (reg_wdata),
    .ceil_act  (ceil_act),
    .ceil_load (ceil_load),
    .ceil_new  (ceil_new),
    .cnt       (cnt),
    .dir       (dir),
    .wrap      (wrap)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_CTRL: begin
        reg_rdata[CTL_RUN]       = run_q;
        reg_rdata[CTL_PRE]       = pre_q;
        reg_rdata[CTL_MODE +: 2] = mode_q;
        reg_rdata[CTL_DIR]       = dir;
        reg_rdata[CTL_FLAG]      = flag_q;
      end
      ADDR_CEIL: reg_rdata = ceil_act;
      ADDR_CNT:  reg_rdata = cnt;
      default:   reg_rdata = ceil_shd;
    endcase
  end

  // R12
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!run_q && !cnt_wr && !ceil_load) |=> $stable(cnt));

  // R2
  plain_step_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (run_q && mode_q == MODE_UP && !cnt_wr && !ceil_load && cnt < ceil_act)
      |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wrap |=> flag_q);

endmodule

// File: tb/test_qenc_timer.sv
module test_qenc_timer;
  localparam int W = 16;

  logic         clk;
  logic         rst_n;
  logic         enc_a, enc_b;
  logic         reg_wr;
  logic [1:0]   reg_addr;
  logic [W-1:0] reg_wdata;
  logic [W-1:0] reg_rdata;

  int checks = 0;
  int errors = 0;

  qenc_timer #(.CNT_W(W)) i_qenc_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .enc_a     (enc_a),
    .enc_b     (enc_b),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {mode[1:0], a, b, expected count[15:0], expected dir}
  localparam int NVEC = 22;
  localparam logic [20:0] VEC [NVEC] = '{
    {2'd3, 1'b1, 1'b0, 16'd101, 1'b0},
    {2'd3, 1'b1, 1'b1, 16'd102, 1'b0},
    {2'd3, 1'b0, 1'b1, 16'd103, 1'b0},
    {2'd3, 1'b0, 1'b0, 16'd104, 1'b0},
    {2'd3, 1'b0, 1'b1, 16'd103, 1'b1},
    {2'd3, 1'b1, 1'b1, 16'd102, 1'b1},
    {2'd3, 1'b1, 1'b0, 16'd101, 1'b1},
    {2'd3, 1'b0, 1'b0, 16'd100, 1'b1},
    {2'd1, 1'b1, 1'b0, 16'd101, 1'b0},
    {2'd1, 1'b1, 1'b1, 16'd101, 1'b0},
    {2'd1, 1'b0, 1'b1, 16'd102, 1'b0},
    {2'd1, 1'b0, 1'b0, 16'd102, 1'b0},
    {2'd1, 1'b0, 1'b1, 16'd102, 1'b0},
    {2'd1, 1'b1, 1'b1, 16'd101, 1'b1},
    {2'd2, 1'b1, 1'b0, 16'd100, 1'b1},
    {2'd2, 1'b0, 1'b0, 16'd100, 1'b1},
    {2'd2, 1'b0, 1'b1, 16'd99,  1'b1},
    {2'd2, 1'b1, 1'b1, 16'd99,  1'b1},
    {2'd2, 1'b0, 1'b1, 16'd99,  1'b1},
    {2'd2, 1'b0, 1'b0, 16'd100, 1'b0},
    {2'd3, 1'b1, 1'b1, 16'd100, 1'b0},
    {2'd3, 1'b0, 1'b0, 16'd100, 1'b0}
  };

  function automatic logic [W-1:0] ctl(input logic run, input logic pre,
                                       input logic [1:0] mode,
                                       input logic clr, input logic upd);
    logic [W-1:0] v;
    v = '0;
    v[0] = run;
    v[1] = pre;
    v[3:2] = mode;
    v[5] = clr;
    v[6] = upd;
    return v;
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // called at a falling edge; the write lands on the next rising edge
  task automatic wr(input logic [1:0] addr, input logic [W-1:0] data);
    reg_wr    = 1'b1;
    reg_addr  = addr;
    reg_wdata = data;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic rd(input logic [1:0] addr, output logic [W-1:0] data);
    reg_addr = addr;
    #1;
    data = reg_rdata;
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #4000000;
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [W-1:0] v;
    rst_n = 1'b0;
    enc_a = 1'b0;
    enc_b = 1'b0;
    reg_wr = 1'b0;
    reg_addr = 2'd0;
    reg_wdata = '0;
    waitn(3);
    rst_n = 1'b1;
    waitn(3);

    // R1 reset state
    rd(2'd0, v); chk("R1 ctrl", v, 16'd0);
    rd(2'd1, v); chk("R1 ceiling", v, 16'hFFFF);
    rd(2'd2, v); chk("R1 count", v, 16'd0);
    rd(2'd3, v); chk("R1 buffered", v, 16'hFFFF);

    // R10 immediate ceiling, then R13 latency
    wr(2'd1, 16'd1000);
    rd(2'd1, v); chk("R10 ceiling", v, 16'd1000);
    wr(2'd2, 16'd100);
    wr(2'd0, ctl(1'b1, 1'b0, 2'd3, 1'b0, 1'b0));
    enc_a = 1'b1;
    waitn(2);
    rd(2'd2, v); chk("R13 before third edge", v, 16'd100);
    waitn(1);
    rd(2'd2, v); chk("R13 at third edge", v, 16'd101);
    enc_a = 1'b0;
    waitn(4);
    rd(2'd2, v); chk("R5 back", v, 16'd100);

    // table walk: R3 R4 R5 R6 R7
    for (int i = 0; i < NVEC; i++) begin
      string tag;
      logic [1:0] m;
      m = VEC[i][20:19];
      tag = (i >= 20) ? "R7" : (m == 2'd1) ? "R3" : (m == 2'd2) ? "R4" : "R5";
      wr(2'd0, ctl(1'b1, 1'b0, m, 1'b0, 1'b0));
      enc_a = VEC[i][18];
      enc_b = VEC[i][17];
      waitn(4);
      rd(2'd2, v); chk($sformatf("%s count vec %0d", tag, i), v, VEC[i][16:1]);
      rd(2'd0, v); chk($sformatf("R6 dir vec %0d", i), {15'd0, v[4]}, {15'd0, VEC[i][0]});
    end

    // R2 plain counting, encoder toggles ignored
    wr(2'd0, ctl(1'b0, 1'b0, 2'd0, 1'b0, 1'b0));
    wr(2'd2, 16'd5);
    wr(2'd0, ctl(1'b1, 1'b0, 2'd0, 1'b0, 1'b0));
    enc_a = 1'b1; waitn(1);
    enc_b = 1'b1; waitn(1);
    enc_a = 1'b0; waitn(1);
    enc_b = 1'b0; waitn(1);
    wr(2'd0, ctl(1'b0, 1'b0, 2'd0, 1'b0, 1'b0));
    rd(2'd2, v); chk("R2 plain count", v, 16'd10);
    rd(2'd0, v); chk("R6 dir forward plain", {15'd0, v[4]}, 16'd0);
    waitn(5);
    rd(2'd2, v); chk("R12 stopped", v, 16'd10);

    // R8 wrap at the top, R9 shrink clears count
    wr(2'd1, 16'd3);
    rd(2'd2, v); chk("R9 shrink clears", v, 16'd0);
    wr(2'd2, 16'd2);
    wr(2'd0, ctl(1'b1, 1'b0, 2'd0, 1'b0, 1'b0));
    waitn(1);
    wr(2'd0, ctl(1'b0, 1'b0, 2'd0, 1'b0, 1'b0));
    rd(2'd2, v); chk("R8 wrap to zero", v, 16'd0);
    rd(2'd0, v); chk("R8 flag set", {15'd0, v[5]}, 16'd1);
    waitn(3);
    rd(2'd0, v); chk("R8 flag sticky", {15'd0, v[5]}, 16'd1);
    wr(2'd0, ctl(1'b0, 1'b0, 2'd0, 1'b1, 1'b0));
    rd(2'd0, v); chk("R8 flag cleared", {15'd0, v[5]}, 16'd0);

    // R8 wrap at the bottom
    wr(2'd0, ctl(1'b1, 1'b0, 2'd3, 1'b0, 1'b0));
    enc_b = 1'b1;
    waitn(4);
    wr(2'd0, ctl(1'b0, 1'b0, 2'd3, 1'b0, 1'b0));
    rd(2'd2, v); chk("R8 wrap to ceiling", v, 16'd3);
    rd(2'd0, v); chk("R8 flag on underflow", {15'd0, v[5]}, 16'd1);
    rd(2'd0, v); chk("R6 dir backward", {15'd0, v[4]}, 16'd1);
    wr(2'd0, ctl(1'b0, 1'b0, 2'd3, 1'b1, 1'b0));

    // R9 count writes against the ceiling
    wr(2'd1, 16'd1000);
    wr(2'd2, 16'd500);
    wr(2'd1, 16'd10);
    rd(2'd2, v); chk("R9 shrink below count", v, 16'd0);
    wr(2'd2, 16'd11);
    rd(2'd2, v); chk("R9 write above ceiling ignored", v, 16'd0);
    wr(2'd2, 16'd10);
    rd(2'd2, v); chk("R9 write at ceiling", v, 16'd10);

    // R11 buffered ceiling and reload trigger
    wr(2'd0, ctl(1'b0, 1'b1, 2'd3, 1'b0, 1'b0));
    wr(2'd1, 16'd20);
    rd(2'd1, v); chk("R11 active held", v, 16'd10);
    rd(2'd3, v); chk("R11 buffered value", v, 16'd20);
    wr(2'd0, ctl(1'b0, 1'b1, 2'd3, 1'b0, 1'b1));
    rd(2'd1, v); chk("R11 reload applied", v, 16'd20);
    rd(2'd0, v); chk("R11 trigger reads zero", {15'd0, v[6]}, 16'd0);

    // R12 frozen in an encoder mode
    enc_a = 1'b1;
    waitn(4);
    enc_b = 1'b0;
    waitn(4);
    rd(2'd2, v); chk("R12 frozen in x4", v, 16'd10);

    finish_run();
  end
endmodule